// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O peripheral on a simple 32-bit register bus. The bus has an address, write data, a write strobe, a read strobe and registered read data. Each group of 32 pins has its own register set. A set has these controls:
- a direction mask;
- an output latch, with atomic bit-set and bit-clear aliases;
- a synchronized view of the pin levels;
- rising-edge and falling-edge detect enables, each with set and clear aliases;
- a status word whose bits are cleared by writing one.

Each register set feeds two interrupt lines, one for each 16-pin half. A global bank-enable word gates every line. Each line is a level: it stays high while its enabled half holds any pending status bit.

Software uses it as follows. It sets pin directions and drives outputs through the set and clear aliases, so it never has to read, modify and write the latch. It arms the edges it cares about, enables the banks it wants and services an interrupt by reading the status word. It acknowledges pending bits by writing ones to them. Pin multiplexing, pads and clock generation are outside this block.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: A direction bit of 1 makes the pin an input and a bit of 0 makes it an output. The output enable `pin_oe` bit is 1 exactly for pins whose direction bit is 0.
- R2: Writing a mask to the bit-set alias (word 2 of a set) sets the latch bits where the mask is 1. Writing a mask to the bit-clear alias (word 3) clears those bits. Bits where the mask is 0 keep their value. Reading either alias returns the latch.
- R3: Writing the output data word (word 1) replaces the latch, and the latch drives `pin_out`.
- R4: Register set k starts at byte offset 0x10 + 0x28*k. Its ten words hold, in order: direction, output data, set-data, clear-data, input level, rise-set, rise-clear, fall-set, fall-clear and status. The bank-enable word is at 0x08.
- R5: The input level word returns the pin level through a two-flop synchronizer, whatever the pin's direction. The new level of a pin changed before edge 1 is returned by a read strobe sampled on edge 3. Strobes sampled on edges 1 and 2 return the old level.
- R6: The rise-set/rise-clear words (words 5 and 6) and the fall-set/fall-clear words (words 7 and 8) set or clear per-pin edge enables. Reading any of the four returns the matching enable mask. Only an enabled edge sets status, and a pin with both enables latches status on either edge.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Status bits are otherwise sticky. An enabled edge detected in the same cycle as a clear of that bit leaves the bit set.
- R8: Interrupt line 2k covers status bits 15:0 of set k, and line 2k+1 covers bits 31:16. Bit n of the bank-enable word gates line n. A line is high while it is enabled and any bit of its half is pending, and it drops only once all of them are cleared.
- R9: After reset, every pin is an input, the latch, the edge enables, the status and the bank enable are 0, and all interrupt lines are low.
- R10: Read data is registered: `bus_rdata` takes the addressed value on the clock edge that samples `bus_rd`. Unmapped or unaligned offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (8) | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32*NUM_SETS (64) | Asynchronous pin levels |
| pin_out | output | 32*NUM_SETS (64) | Output latch value |
| pin_oe | output | 32*NUM_SETS (64) | Output enable, 1 = driven |
| bank_irq | output | 2*NUM_SETS (4) | Per-half interrupt levels |

## Verification
A register write takes effect on the edge that samples the strobe. The latch, direction and enable results, and the interrupt gating that follows a bank-enable write, are checked on the next falling edge. A pin change applied just before edge 1 appears in status after edge 3, so the bench waits three full cycles before it reads status or looks at an interrupt line. The input-level word is read on edges 1, 2 and 3 to pin down the two-flop delay. The same-cycle race between a clear and an edge is set up by starting the clear write exactly two cycles after the pin change, so the clear commits on the edge where the edge detection is registered.

// File: rtl/gpio_edge_pkg.sv
// Shared constants and the word index type for the GPIO edge controller.
// Assumes byte addressing with 32-bit words.
package gpio_edge_pkg;

    localparam int DATA_W        = 32;
    localparam int HALF_W        = 16;
    localparam int WORDS_PER_SET = 10;
    localparam int SET_BASE0     = 'h10;
    localparam int SET_STRIDE    = 'h28;
    localparam int BANK_EN_OFS   = 'h08;

    // Word position inside one register set; the order is the address map.
    typedef enum logic [3:0] {
        IDX_DIR      = 4'd0,
        IDX_OUT      = 4'd1,
        IDX_OUT_SET  = 4'd2,
        IDX_OUT_CLR  = 4'd3,
        IDX_LEVEL    = 4'd4,
        IDX_RISE_SET = 4'd5,
        IDX_RISE_CLR = 4'd6,
        IDX_FALL_SET = 4'd7,
        IDX_FALL_CLR = 4'd8,
        IDX_STAT     = 4'd9
    } reg_idx_e;

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop input synchronizer followed by a one-cycle delay stage for
// edge detection. Assumes pins are asynchronous to clk and that an
// edge lasts at least two cycles to be seen reliably.
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    // Purpose: resynchronize the pins and keep last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Purpose: flag one-cycle rising and falling transitions.
    always_comb begin
        rise_o = sync_q & ~prev_q;
        fall_o = ~sync_q & prev_q;
    end

    assign lvl_o = sync_q;

endmodule

// File: rtl/gpio_reg_set.sv
// One 32-pin register set: direction, output latch with set/clear
// aliases, edge enables with set/clear aliases and write-one-to-clear
// status. Assumes wr_en is already qualified by the address decode.
module gpio_reg_set
    import gpio_edge_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_idx_e     wr_idx,
    input  logic [W-1:0] wr_data,
    input  reg_idx_e     rd_idx,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    output logic [W-1:0] rd_val,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q,
    output logic [W-1:0] stat_q
);

    logic [W-1:0] rise_en_q;
    logic [W-1:0] fall_en_q;
    logic [W-1:0] hit;
    logic [W-1:0] ack;

    // Purpose: direction, latch and edge-enable updates from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q     <= '1;
            out_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_DIR:      dir_q     <= wr_data;
                IDX_OUT:      out_q     <= wr_data;
                IDX_OUT_SET:  out_q     <= out_q | wr_data;
                IDX_OUT_CLR:  out_q     <= out_q & ~wr_data;
                IDX_RISE_SET: rise_en_q <= rise_en_q | wr_data;
                IDX_RISE_CLR: rise_en_q <= rise_en_q & ~wr_data;
                IDX_FALL_SET: fall_en_q <= fall_en_q | wr_data;
                IDX_FALL_CLR: fall_en_q <= fall_en_q & ~wr_data;
                default:      ;
            endcase
        end
    end

    // Purpose: enabled edges and the write-one-to-clear mask.
    always_comb begin
        hit = (rise & rise_en_q) | (fall & fall_en_q);
        ack = (wr_en && wr_idx == IDX_STAT) ? wr_data : '0;
    end

    // Purpose: sticky status; a new edge wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~ack) | hit;
    end

    // Purpose: readback of the addressed word; aliases return their target.
    always_comb begin
        case (rd_idx)
            IDX_DIR:                               rd_val = dir_q;
            IDX_OUT, IDX_OUT_SET, IDX_OUT_CLR:     rd_val = out_q;
            IDX_LEVEL:                             rd_val = lvl;
            IDX_RISE_SET, IDX_RISE_CLR:            rd_val = rise_en_q;
            IDX_FALL_SET, IDX_FALL_CLR:            rd_val = fall_en_q;
            IDX_STAT:                              rd_val = stat_q;
            default:                               rd_val = '0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_ctrl.sv
// Top of the banked GPIO controller. Decodes the register bus onto
// NUM_SETS register sets plus a global bank-enable word, registers
// read data and forms one gated interrupt level per 16-pin half.
// Assumes ADDR_W covers the last set (>= 8 bits for two sets).
module gpio_edge_ctrl
    import gpio_edge_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    output logic [DATA_W-1:0]          bus_rdata,
    input  logic [NUM_SETS*DATA_W-1:0] pin_in,
    output logic [NUM_SETS*DATA_W-1:0] pin_out,
    output logic [NUM_SETS*DATA_W-1:0] pin_oe,
    output logic [2*NUM_SETS-1:0]      bank_irq
);

    localparam int NUM_PINS  = NUM_SETS * DATA_W;
    localparam int NUM_BANKS = 2 * NUM_SETS;
    localparam logic [ADDR_W-1:0] BANK_EN_A = ADDR_W'(BANK_EN_OFS);

    logic [NUM_BANKS-1:0]  bank_en_q;
    logic [NUM_PINS-1:0]   stat_all;
    logic [NUM_PINS-1:0]   dir_all;
    logic [NUM_PINS-1:0]   lvl_all;
    logic [NUM_PINS-1:0]   rise_all;
    logic [NUM_PINS-1:0]   fall_all;
    logic [NUM_SETS-1:0]   set_hit;
    logic [DATA_W-1:0]     set_rd [NUM_SETS];
    logic [DATA_W-1:0]     rd_next;

    // Pin synchronization and edge detection across all pins.
    gpio_in_sync #(.W(NUM_PINS)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_in),
        .lvl_o  (lvl_all),
        .rise_o (rise_all),
        .fall_o (fall_all)
    );

    for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
        localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(SET_BASE0 + k * SET_STRIDE);
        localparam logic [ADDR_W-1:0] END_A  =
            ADDR_W'(SET_BASE0 + k * SET_STRIDE + 4 * WORDS_PER_SET);

        logic [ADDR_W-1:0] rel;
        reg_idx_e          idx;

        // Purpose: match this set's window and pick the word index.
        always_comb begin
            rel        = bus_addr - BASE_A;
            idx        = reg_idx_e'(rel[5:2]);
            set_hit[k] = (bus_addr >= BASE_A) && (bus_addr < END_A) &&
                         (bus_addr[1:0] == 2'b00);
        end

        gpio_reg_set #(.W(DATA_W)) regs_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bus_wr && set_hit[k]),
            .wr_idx  (idx),
            .wr_data (bus_wdata),
            .rd_idx  (idx),
            .lvl     (lvl_all [k*DATA_W +: DATA_W]),
            .rise    (rise_all[k*DATA_W +: DATA_W]),
            .fall    (fall_all[k*DATA_W +: DATA_W]),
            .rd_val  (set_rd[k]),
            .dir_q   (dir_all [k*DATA_W +: DATA_W]),
            .out_q   (pin_out [k*DATA_W +: DATA_W]),
            .stat_q  (stat_all[k*DATA_W +: DATA_W])
        );
    end

    // Purpose: global bank-enable word.
    always_ff @(posedge clk) begin
        if (!rst_n)                              bank_en_q <= '0;
        else if (bus_wr && bus_addr == BANK_EN_A) bank_en_q <= bus_wdata[NUM_BANKS-1:0];
    end

    // Purpose: select read data; unmapped offsets give zero.
    always_comb begin
        rd_next = '0;
        if (bus_addr == BANK_EN_A) rd_next = DATA_W'(bank_en_q);
        for (int k = 0; k < NUM_SETS; k++) begin
            if (set_hit[k]) rd_next = set_rd[k];
        end
    end

    // Purpose: register read data on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    // Purpose: active-high output enable from the input-high direction bits.
    assign pin_oe = ~dir_all;

    // One gated level per 16-pin half.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign bank_irq[b] = bank_en_q[b] & (|stat_all[b*HALF_W +: HALF_W]);
    end

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
// Property checker for gpio_edge_ctrl, attached by bind. Watches the
// bus, pins, interrupt lines and the status and bank-enable state.
module gpio_edge_ctrl_chk
    import gpio_edge_pkg::*;
#(
    parameter int NUM_SETS = 2,
    parameter int ADDR_W   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_wdata,
    input logic                       bus_wr,
    input logic [NUM_SETS*DATA_W-1:0] pin_out,
    input logic [NUM_SETS*DATA_W-1:0] pin_oe,
    input logic [2*NUM_SETS-1:0]      bank_irq,
    input logic [2*NUM_SETS-1:0]      bank_en_q,
    input logic [NUM_SETS*DATA_W-1:0] stat_all
);

    localparam logic [ADDR_W-1:0] OSET0_A = ADDR_W'(SET_BASE0 + 4 * int'(IDX_OUT_SET));
    localparam logic [ADDR_W-1:0] OCLR0_A = ADDR_W'(SET_BASE0 + 4 * int'(IDX_OUT_CLR));
    localparam logic [ADDR_W-1:0] STAT0_A = ADDR_W'(SET_BASE0 + 4 * int'(IDX_STAT));

    a_r2_set_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OSET0_A) |=>
        ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

    a_r2_clr_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OCLR0_A) |=>
        ((pin_out[31:0] & $past(bus_wdata)) == '0));

    // R7: bits written with 0 survive a status write.
    a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == STAT0_A) |=>
        ((stat_all[31:0] & $past(stat_all[31:0]) & ~$past(bus_wdata)) ==
         ($past(stat_all[31:0]) & ~$past(bus_wdata))));

    // R7: without a status write, pending bits stay pending.
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == STAT0_A) |=>
        ((stat_all[31:0] & $past(stat_all[31:0])) == $past(stat_all[31:0])));

    for (genvar b = 0; b < 2 * NUM_SETS; b++) begin : g_irq
        a_r8_drop_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(bank_irq[b]) |->
            ((stat_all[b*HALF_W +: HALF_W] == '0) || !bank_en_q[b]));
    end

    a_r9_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_out == '0 && bank_irq == '0));

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(
    .NUM_SETS (NUM_SETS),
    .ADDR_W   (ADDR_W)
) chk_i (.*);

// File: tb/gpio_edge_ctrl_tb_top.sv
`timescale 1ns/1ps
// Directed bench for gpio_edge_ctrl. Every task starts and ends on a
// falling clock edge; writes commit on the rising edge in between.
module gpio_edge_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out;
    logic [63:0] pin_oe;
    logic [3:0]  bank_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_edge_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .bank_irq(bank_irq)
    );

    // Register offsets (set 0 at 0x10, set 1 at 0x38).
    localparam logic [7:0] A_BEN  = 8'h08;
    localparam logic [7:0] A_DIR0 = 8'h10, A_OUT0 = 8'h14, A_OSET0 = 8'h18, A_OCLR0 = 8'h1C;
    localparam logic [7:0] A_RSET0 = 8'h24, A_RCLR0 = 8'h28, A_FSET0 = 8'h2C, A_STAT0 = 8'h34;
    localparam logic [7:0] A_DIR1 = 8'h38, A_OSET1 = 8'h40, A_LVL1 = 8'h48;
    localparam logic [7:0] A_RSET1 = 8'h4C, A_STAT1 = 8'h5C;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        chk("R9 pin_oe", pin_oe, 64'h0);
        chk("R9 pin_out", pin_out, 64'h0);
        chk("R9 bank_irq", 64'(bank_irq), 64'h0);
        rd(A_DIR0, d); chk("R9 dir0", 64'(d), 64'hFFFF_FFFF);
        rd(A_BEN, d);  chk("R9 bank enable", 64'(d), 64'h0);
        rd(A_STAT1, d); chk("R9 status1", 64'(d), 64'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        wr(A_DIR0, 32'h0);
        rd(8'h00, d); chk("R10 unmapped 0x00", 64'(d), 64'h0);
        rd(8'h0C, d); chk("R10 unmapped 0x0C", 64'(d), 64'h0);
        rd(8'h60, d); chk("R10 unmapped 0x60", 64'(d), 64'h0);
        rd(8'hFC, d); chk("R10 unmapped 0xFC", 64'(d), 64'h0);
        rd(8'h11, d); chk("R10 unaligned 0x11", 64'(d), 64'h0);
        rd(A_DIR0, d); chk("R4 dir0 readback", 64'(d), 64'h0);
    endtask

    task automatic t_dir_out;
        logic [31:0] d;
        wr(A_DIR0, 32'hFFFF_0000);
        chk("R1 oe set0", 64'(pin_oe[31:0]), 64'h0000_FFFF);
        wr(A_DIR1, 32'h0);
        chk("R1 oe set1", 64'(pin_oe[63:32]), 64'hFFFF_FFFF);
        wr(A_OUT0, 32'h1234_5678);
        chk("R3 out write", 64'(pin_out[31:0]), 64'h1234_5678);
        wr(A_OSET0, 32'h0000_FF00);
        chk("R2 set alias", 64'(pin_out[31:0]), 64'h1234_FF78);
        wr(A_OCLR0, 32'h0030_0008);
        chk("R2 clear alias", 64'(pin_out[31:0]), 64'h1204_FF70);
        rd(A_OSET0, d); chk("R2 alias readback", 64'(d), 64'h1204_FF70);
        wr(A_OSET1, 32'h8000_0001);
        chk("R4 set1 latch", 64'(pin_out[63:32]), 64'h8000_0001);
    endtask

    task automatic t_level;
        logic [31:0] d;
        pin_in[63:32] = 32'hA5A5_A5A5;
        rd(A_LVL1, d); chk("R5 level edge1 old", 64'(d), 64'h0);
        rd(A_LVL1, d); chk("R5 level edge2 old", 64'(d), 64'h0);
        rd(A_LVL1, d); chk("R5 level edge3 new (output pins)", 64'(d), 64'hA5A5_A5A5);
        pin_in = '0;
        idle(4);
    endtask

    task automatic t_edges;
        logic [31:0] d;
        wr(A_RSET0, 32'h0000_000F);
        wr(A_FSET0, 32'h0000_003C);
        pin_in[31:0] = 32'h0000_0011;
        idle(3);
        rd(A_STAT0, d); chk("R6 rising only enabled", 64'(d), 64'h1);
        wr(A_STAT0, 32'hFFFF_FFFF);
        rd(A_STAT0, d); chk("R7 w1c clears", 64'(d), 64'h0);
        pin_in[31:0] = 32'h0;
        idle(3);
        rd(A_STAT0, d); chk("R6 falling only enabled", 64'(d), 64'h10);
        wr(A_STAT0, 32'hFFFF_FFFF);
        wr(A_RCLR0, 32'h1);
        rd(A_RSET0, d); chk("R6 enable readback", 64'(d), 64'hE);
        pin_in[31:0] = 32'h1;
        idle(3);
        rd(A_STAT0, d); chk("R6 cleared enable", 64'(d), 64'h0);
        pin_in[31:0] = 32'h4;
        idle(3);
        rd(A_STAT0, d); chk("R6 both edges rise", 64'(d), 64'h4);
        wr(A_STAT0, 32'h4);
        pin_in[31:0] = 32'h0;
        idle(3);
        rd(A_STAT0, d); chk("R6 both edges fall", 64'(d), 64'h4);
    endtask

    task automatic t_w1c;
        logic [31:0] d;
        wr(A_STAT0, 32'h0);
        rd(A_STAT0, d); chk("R7 zero write no effect", 64'(d), 64'h4);
        pin_in[31:0] = 32'h4;
        idle(2);
        wr(A_STAT0, 32'h4);
        rd(A_STAT0, d); chk("R7 edge wins over clear", 64'(d), 64'h4);
        wr(A_STAT0, 32'hFFFF_FFFF);
        rd(A_STAT0, d); chk("R7 cleared after race", 64'(d), 64'h0);
    endtask

    task automatic t_irq;
        logic [31:0] d;
        wr(A_RSET0, 32'h0003_0000);
        wr(A_RSET1, 32'h0010_0000);
        pin_in[17:16] = 2'b11;
        pin_in[52]    = 1'b1;
        idle(3);
        chk("R8 gated off", 64'(bank_irq), 64'h0);
        wr(A_BEN, 32'hF);
        chk("R8 upper halves", 64'(bank_irq), 64'hA);
        wr(A_STAT0, 32'h0001_0000);
        chk("R8 holds while pending", 64'(bank_irq), 64'hA);
        wr(A_STAT0, 32'h0002_0000);
        chk("R8 drops when clear", 64'(bank_irq), 64'h8);
        wr(A_BEN, 32'h7);
        chk("R8 enable gates line 3", 64'(bank_irq), 64'h0);
        wr(A_STAT1, 32'h0010_0000);
        wr(A_BEN, 32'hF);
        chk("R8 none pending", 64'(bank_irq), 64'h0);
        rd(A_BEN, d); chk("R4 bank enable readback", 64'(d), 64'hF);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset;
        t_unmapped;
        t_dir_out;
        t_level;
        t_edges;
        t_w1c;
        t_irq;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule